// File: doc/BRIEF.md
# Multi-Mode Three-Axis Sample Buffer

This block queues three-axis sample triples (16 bits per axis) between a sensor front end and a host. A write strobe offers one triple per cycle, and a pop strobe takes one. The oldest stored triple is always shown on the head outputs. A pop consumes the whole triple at once. The storage is a ring of `DEPTH` entries plus one output holding stage, so the reported level runs from 0 up to `DEPTH+1`.

A 2-bit mode input selects the policy for a write that arrives when there is no room:
- single-level replacement,
- stop-when-full,
- streaming that keeps the newest samples,
- trigger capture.

In trigger capture the block keeps a programmable window of the newest samples until a trigger pulse arrives. After the trigger it fills the rest of the buffer and then stops. A watermark flag compares the level with the programmed setting. An overrun flag reports lost or displaced data. Any change of the mode input empties the buffer.

Top module: `sample_fifo`

## Requirements
- R1: After reset the level is 0 and the overrun and trigger-seen flags are 0.
- R2: The mode encoding is 00 single-level, 01 stop-when-full, 10 streaming and 11 trigger capture. In mode 01 triples come out in write order, and the level never exceeds `DEPTH+1` (33). Writes offered at level 33 are dropped and the stored data is kept.
- R3: In mode 01 at level 33, a write together with a pop is accepted. The level stays 33 and the new triple becomes the newest entry.
- R4: In mode 10 a write at level 33 discards the oldest entry, so the buffer holds the 33 newest triples.
- R5: In mode 00 the level is at most 1. A write replaces the held triple. Replacing an unread triple (no pop in that cycle) sets the overrun flag.
- R6: In mode 11 before the trigger, the level is limited to the watermark setting N, and a write at level N discards the oldest entry. When N is 0, writes are not stored.
- R7: In mode 11 a one-cycle trigger pulse sets the trigger-seen flag on the next edge. After that, writes are kept until level 33, and later writes are dropped.
- R8: The watermark flag equals (level >= N), N being the 5-bit setting. With N = 0 it is 1 even when the buffer is empty.
- R9: In modes 01, 10 and 11 the overrun flag sets when the level reaches 33. In every mode it clears on the edge that takes a pop from a non-empty buffer.
- R10: A change of the mode input empties the buffer and clears the overrun and trigger-seen flags at the next edge. A write or pop offered in that cycle is ignored.
- R11: A pop from an empty buffer has no effect. Each pop removes one full triple, whose three axes were written together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_wr | input | 1 | Offer one sample triple this cycle |
| smp_x | input | 16 | X axis of offered sample |
| smp_y | input | 16 | Y axis of offered sample |
| smp_z | input | 16 | Z axis of offered sample |
| host_pop | input | 1 | Consume the head triple |
| trig_in | input | 1 | Trigger pulse, used in mode 11 |
| mode_sel | input | 2 | Operating mode (R2 encoding) |
| wm_level | input | 5 | Watermark / pre-trigger setting N |
| head_x | output | 16 | X axis of the oldest stored triple |
| head_y | output | 16 | Y axis of the oldest stored triple |
| head_z | output | 16 | Z axis of the oldest stored triple |
| level | output | 6 | Stored triples, 0 to 33 |
| wm_flag | output | 1 | Level at or above the setting |
| ovr_flag | output | 1 | Overrun |
| trig_seen | output | 1 | Trigger captured in mode 11 |

## Verification
A wrong read or write pointer, or a lost hand-off between the ring and the output stage, shows up as a head value that breaks the write-order sequence. The bench encodes a running index in every axis, so such an error appears at the first pop after it. A wrong level, for example a miscounted output stage, shows at once on `level` and on the watermark flag. A wrong full or limit decision shows one edge after the write that should have been dropped or should have displaced the oldest entry: the level is off by one, or the head index is wrong. Each drain re-reads the full contents, so stale flush or trigger state is exposed on the first sample.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
    localparam int SAMPLE_W = 16;

    typedef enum logic [1:0] {
        MODE_SINGLE = 2'b00,
        MODE_HOLD   = 2'b01,
        MODE_STREAM = 2'b10,
        MODE_TRIG   = 2'b11
    } sbuf_mode_e;

    typedef struct packed {
        logic [SAMPLE_W-1:0] x;
        logic [SAMPLE_W-1:0] y;
        logic [SAMPLE_W-1:0] z;
    } triple_t;

    // Modes in which a write with no room displaces the oldest entry.
    function automatic logic displaces_oldest(sbuf_mode_e m, logic seen);
        return (m == MODE_SINGLE) || (m == MODE_STREAM) || (m == MODE_TRIG && !seen);
    endfunction
endpackage

// File: rtl/sbuf_ring.sv
module sbuf_ring #(
    parameter int DEPTH = 32,
    parameter int W     = 48,
    localparam int AW   = $clog2(DEPTH),
    localparam int FW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  head,
    output logic [FW-1:0] fill
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (push) wptr <= nxt(wptr);
            if (pop)  rptr <= nxt(rptr);
            fill <= fill + FW'(push) - FW'(pop);
        end
    end

    assign head = mem[rptr];

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !flush) |-> (fill < FW'(DEPTH)));
    // R11
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !flush) |-> (fill != '0));
endmodule

// File: rtl/sbuf_policy.sv
module sbuf_policy
    import sbuf_pkg::*;
#(
    parameter int CAP = 33,
    parameter int LW  = 5,
    localparam int CW = $clog2(CAP + 1)
) (
    input  sbuf_mode_e    mode,
    input  logic          seen,
    input  logic [CW-1:0] total,
    input  logic          head_valid,
    input  logic          wr,
    input  logic          pop,
    input  logic [LW-1:0] lvl,
    output logic          do_pop,
    output logic          add,
    output logic          replace,
    output logic          ovr_set
);
    logic [CW-1:0] limit, after, nxt_total;
    logic          room, may_rep;

    always_comb begin
        unique case (mode)
            MODE_SINGLE: limit = CW'(1);
            MODE_TRIG:   limit = seen ? CW'(CAP) : CW'(lvl);
            default:     limit = CW'(CAP);
        endcase
        do_pop    = pop && head_valid;
        after     = total - CW'(do_pop);
        room      = after < limit;
        may_rep   = displaces_oldest(mode, seen) && (limit != '0);
        add       = wr && (room || may_rep);
        replace   = wr && !room && may_rep;
        nxt_total = after + CW'(add) - CW'(replace);
        ovr_set   = (mode == MODE_SINGLE) ? replace
                                          : (add && nxt_total == CW'(CAP));
    end
endmodule

// File: rtl/sample_fifo.sv
module sample_fifo
    import sbuf_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int LVL_W  = 5,
    localparam int CAP   = DEPTH + 1,
    localparam int CW    = $clog2(CAP + 1),
    localparam int RFW   = $clog2(DEPTH + 1),
    localparam int TW    = $bits(triple_t)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_wr,
    input  logic [SAMPLE_W-1:0] smp_x,
    input  logic [SAMPLE_W-1:0] smp_y,
    input  logic [SAMPLE_W-1:0] smp_z,
    input  logic                host_pop,
    input  logic                trig_in,
    input  logic [1:0]          mode_sel,
    input  logic [LVL_W-1:0]    wm_level,
    output logic [SAMPLE_W-1:0] head_x,
    output logic [SAMPLE_W-1:0] head_y,
    output logic [SAMPLE_W-1:0] head_z,
    output logic [CW-1:0]       level,
    output logic                wm_flag,
    output logic                ovr_flag,
    output logic                trig_seen
);
    sbuf_mode_e     mode_in, mode_q;
    logic           flush;
    triple_t        wr_t, out_reg, ring_head_t;
    logic           out_v;
    logic [TW-1:0]  ring_head;
    logic [RFW-1:0] fill;
    logic           do_pop, add, replace, ovr_set, rm;
    logic           ring_push, ring_pop, ring_has;

    assign mode_in = sbuf_mode_e'(mode_sel);
    assign flush   = (mode_in != mode_q);
    assign wr_t    = '{x: smp_x, y: smp_y, z: smp_z};
    assign level   = CW'(fill) + CW'(out_v);

    sbuf_policy #(.CAP(CAP), .LW(LVL_W)) u_policy (
        .mode       (mode_q),
        .seen       (trig_seen),
        .total      (level),
        .head_valid (out_v),
        .wr         (smp_wr && !flush),
        .pop        (host_pop && !flush),
        .lvl        (wm_level),
        .do_pop     (do_pop),
        .add        (add),
        .replace    (replace),
        .ovr_set    (ovr_set)
    );

    assign rm        = do_pop || replace;
    assign ring_has  = (fill != '0);
    assign ring_pop  = rm && ring_has;
    assign ring_push = add && ((rm && ring_has) || (!rm && out_v));

    sbuf_ring #(.DEPTH(DEPTH), .W(TW)) u_ring (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .push  (ring_push),
        .pop   (ring_pop),
        .din   (wr_t),
        .head  (ring_head),
        .fill  (fill)
    );
    assign ring_head_t = triple_t'(ring_head);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_SINGLE;
            out_v     <= 1'b0;
            out_reg   <= '0;
            ovr_flag  <= 1'b0;
            trig_seen <= 1'b0;
        end else if (flush) begin
            mode_q    <= mode_in;
            out_v     <= 1'b0;
            ovr_flag  <= 1'b0;
            trig_seen <= 1'b0;
        end else begin
            if (rm) begin
                if (ring_has) begin
                    out_reg <= ring_head_t;
                end else if (add) begin
                    out_reg <= wr_t;
                end else begin
                    out_v   <= 1'b0;
                end
            end else if (add && !out_v) begin
                out_reg <= wr_t;
                out_v   <= 1'b1;
            end
            if (do_pop)       ovr_flag <= 1'b0;
            else if (ovr_set) ovr_flag <= 1'b1;
            if (mode_q == MODE_TRIG && trig_in) trig_seen <= 1'b1;
        end
    end

    assign head_x  = out_reg.x;
    assign head_y  = out_reg.y;
    assign head_z  = out_reg.z;
    assign wm_flag = (level >= CW'(wm_level));

    // R2
    level_cap_chk: assert property (@(posedge clk) disable iff (rst)
        level <= CW'(CAP));
    // R5
    single_level_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SINGLE) |-> (level <= CW'(1)));
    // R3
    hold_full_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_HOLD && !flush && level == CW'(CAP) && smp_wr)
        |=> (level == CW'(CAP)));
    // R7
    trig_mode_chk: assert property (@(posedge clk) disable iff (rst)
        trig_seen |-> (mode_q == MODE_TRIG));
    // R9
    overrun_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag && !host_pop && !flush) |=> ovr_flag);
    // R6
    pretrig_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_TRIG && !trig_seen && !flush && $stable(wm_level)
         && level <= CW'(wm_level)) |=> (level <= CW'(wm_level)));
endmodule

// File: tb/tb_sample_fifo.sv
`timescale 1ns/100ps
module tb_sample_fifo;
    logic        clk = 1'b0;
    logic        rst;
    logic        smp_wr, host_pop, trig_in;
    logic [15:0] smp_x, smp_y, smp_z;
    logic [1:0]  mode_sel;
    logic [4:0]  wm_level;
    logic [15:0] head_x, head_y, head_z;
    logic [5:0]  level;
    logic        wm_flag, ovr_flag, trig_seen;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    sample_fifo dut (
        .clk(clk), .rst(rst), .smp_wr(smp_wr), .smp_x(smp_x), .smp_y(smp_y),
        .smp_z(smp_z), .host_pop(host_pop), .trig_in(trig_in),
        .mode_sel(mode_sel), .wm_level(wm_level), .head_x(head_x),
        .head_y(head_y), .head_z(head_z), .level(level), .wm_flag(wm_flag),
        .ovr_flag(ovr_flag), .trig_seen(trig_seen)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(bit w, int k, bit p, bit t);
        smp_wr = w; smp_x = 16'(k); smp_y = 16'(k + 1000); smp_z = 16'(k + 2000);
        host_pop = p; trig_in = t;
        @(posedge clk); #1;
        smp_wr = 0; host_pop = 0; trig_in = 0;
    endtask

    task automatic write_run(int first, int n);
        for (int i = 0; i < n; i++) step(1, first + i, 0, 0);
    endtask

    task automatic head_is(string req, int k);
        chk(req, int'(head_x), k);
        chk(req, int'(head_y), k + 1000);
        chk(req, int'(head_z), k + 2000);
    endtask

    task automatic set_mode(logic [1:0] m);
        mode_sel = m;
        step(0, 0, 0, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; smp_wr = 0; host_pop = 0; trig_in = 0;
        smp_x = 0; smp_y = 0; smp_z = 0; mode_sel = 2'b00; wm_level = 5'd4;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        chk("R1 level", level, 0);
        chk("R1 ovr", ovr_flag, 0);
        chk("R1 trig", trig_seen, 0);

        // R2 stop-when-full mode
        set_mode(2'b01);
        write_run(0, 40);
        chk("R2 level full", level, 33);
        chk("R9 ovr at full", ovr_flag, 1);
        chk("R8 wm full", wm_flag, 1);
        for (int i = 0; i < 33; i++) begin
            head_is("R2 order", i);
            step(0, 0, 1, 0);
            chk("R2 level drain", level, 32 - i);
            chk("R8 wm sweep", wm_flag, (32 - i) >= 4);
            if (i == 0) chk("R9 ovr clear", ovr_flag, 0);
        end
        // R11 pop on empty
        step(0, 0, 1, 0);
        chk("R11 empty pop", level, 0);

        // R3 full write with pop
        write_run(100, 33);
        step(1, 200, 1, 0);
        chk("R3 level", level, 33);
        for (int i = 0; i < 33; i++) begin
            head_is("R3 order", (i < 32) ? 101 + i : 200);
            step(0, 0, 1, 0);
        end
        chk("R3 drained", level, 0);

        // R8 zero setting
        wm_level = 5'd0; #1;
        chk("R8 wm zero empty", wm_flag, 1);
        wm_level = 5'd4; #1;
        chk("R8 wm below", wm_flag, 0);

        // R4 streaming
        write_run(900, 3);
        set_mode(2'b10);
        chk("R10 flush level", level, 0);
        write_run(300, 50);
        chk("R4 level", level, 33);
        chk("R9 ovr stream", ovr_flag, 1);
        for (int i = 0; i < 33; i++) begin
            head_is("R4 newest", 317 + i);
            step(0, 0, 1, 0);
        end

        // R5 single-level
        set_mode(2'b00);
        step(1, 400, 0, 0);
        chk("R5 level", level, 1);
        head_is("R5 held", 400);
        chk("R5 no ovr", ovr_flag, 0);
        step(1, 401, 0, 0);
        chk("R5 level repl", level, 1);
        head_is("R5 replaced", 401);
        chk("R5 ovr", ovr_flag, 1);
        step(0, 0, 1, 0);
        chk("R9 ovr pop", ovr_flag, 0);
        chk("R5 level pop", level, 0);

        // R6 / R7 trigger capture
        wm_level = 5'd5;
        set_mode(2'b11);
        write_run(500, 10);
        chk("R6 level", level, 5);
        head_is("R6 window", 505);
        chk("R7 not seen", trig_seen, 0);
        step(0, 0, 0, 1);
        chk("R7 seen", trig_seen, 1);
        write_run(600, 40);
        chk("R7 level", level, 33);
        chk("R9 ovr trig", ovr_flag, 1);
        for (int i = 0; i < 33; i++) begin
            head_is("R7 order", (i < 5) ? 505 + i : 600 + i - 5);
            step(0, 0, 1, 0);
        end
        write_run(950, 2);
        set_mode(2'b01);
        chk("R10 trig cleared", trig_seen, 0);
        chk("R10 level", level, 0);

        // R6 zero window
        wm_level = 5'd0;
        set_mode(2'b11);
        step(1, 700, 0, 0);
        chk("R6 zero window", level, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule